// File: doc/BRIEF.md
# Readout Bus Register Decoder

This block is the register front end of a multi-channel waveform digitiser module. It sits behind a simplified slave port with 24-bit addressing and 16-bit data. Each access arrives as a one-cycle strobe that carries an address, an address-modifier code, a direction flag and write data. The top address byte must match the module's own slot index. The low 16 bits select a register, and the modifier code must belong to the access class of that register.

Write accesses can issue a one-clock module reset, but only when a fixed key value is written. They can also load the sampling count and load a per-channel threshold. Read accesses pop one word from the merged event FIFO, which needs a block-transfer modifier. They can also return how many merged-FIFO reads have been accepted, or pop one word from a single channel FIFO with the single-word modifier.

Every accepted access is acknowledged in the cycle after its strobe, and read data is valid in that same cycle. An access that is not decoded is never acknowledged and changes nothing.

Top module: `rbus_decoder`

## Requirements
- R1: An access whose address bits [23:16] differ from `slot_id` gets no acknowledge and changes no state.
- R2: An accepted access raises `bus_ack` for exactly one cycle, the cycle after the strobe, and `bus_rdata` holds the read word in that cycle.
- R3: Writing 0x0100 to offset 0x0000 with modifier 0x3D pulses `mod_reset` high for one cycle, starting the cycle after the strobe. In that same cycle it returns the sampling count and all thresholds to their defaults (80 and 0x0010) and clears the block-read counter.
- R4: Any other data value written to offset 0x0000 is acknowledged but produces no reset pulse and changes no register.
- R5: Writing offset 0x0001 with modifier 0x3D loads `samp_count`, visible the cycle after the strobe.
- R6: Reading offset 0x0100 with modifier 0x3B or 0x3F asserts `mrg_pop` during the strobe cycle and returns the `mrg_data` word present then.
- R7: Reading offset 0x0101 with modifier 0x3B or 0x3F returns the number of merged-FIFO reads accepted since the last reset of either kind.
- R8: Reading offset 0x1000 + 16*j with modifier 0x3D, for channel j below the channel count, asserts only bit j of `ch_pop` during the strobe cycle and returns channel j's word (bits [16j+15:16j] of `ch_data`).
- R9: Writing offset 0x1002 + 16*j with modifier 0x3D loads the threshold of channel j (bits [16j+15:16j] of `thr_flat`) and leaves every other channel's threshold unchanged.
- R10: An access whose modifier does not match the class of its offset gets no acknowledge, no pop and no state change. Block offsets take only 0x3B or 0x3F; every other offset takes only 0x3D.
- R11: An unmapped offset, a channel index at or above the channel count, a read of a write-only register or a write of a read-only register gets no acknowledge and no pop.
- R12: While `rst` is high at a clock edge, `bus_ack` and `mod_reset` clear, `samp_count` and every threshold take their defaults, and the block-read counter clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_id | input | 8 | Slot index this module answers to |
| bus_addr | input | 24 | Access address |
| bus_am | input | 6 | Address-modifier code |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_strobe | input | 1 | One-cycle access request |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access accepted, one cycle after strobe |
| mrg_data | input | 16 | Head word of merged event FIFO |
| mrg_pop | output | 1 | Pop merged FIFO |
| ch_data | input | 512 | Head words of the 32 channel FIFOs, 16 bits each |
| ch_pop | output | 32 | Pop one channel FIFO |
| mod_reset | output | 1 | One-cycle module reset pulse |
| samp_count | output | 16 | Sampling count register |
| thr_flat | output | 512 | Per-channel thresholds, 16 bits each |

## Verification
Each register is reached with its correct modifier and then with the wrong class of modifier. This separates the modifier qualification from the offset decode. The slot byte is varied so that a mismatch is shown to block an otherwise valid write. Channel accesses use the lowest, a middle, the highest and the first out-of-range index, with distinct head words per channel, so that a wrong pop bit or a wrong data lane is caught. The reset offset is written with a near-miss key and then with the real key after other registers were changed. This tells a key-gated reset from one that fires on any write, and shows which registers the reset restores.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    localparam int DW    = 16;
    localparam int AW    = 24;
    localparam int AMW   = 6;
    localparam int CIDXW = 8;

    localparam logic [DW-1:0]  RST_KEY    = 16'h0100;
    localparam logic [AMW-1:0] AM_SINGLE  = 6'h3D;
    localparam logic [AMW-1:0] AM_BLOCK_A = 6'h3B;
    localparam logic [AMW-1:0] AM_BLOCK_B = 6'h3F;

    localparam logic [15:0] OFF_RESET  = 16'h0000;
    localparam logic [15:0] OFF_SAMP   = 16'h0001;
    localparam logic [15:0] OFF_MERGED = 16'h0100;
    localparam logic [15:0] OFF_BLKCNT = 16'h0101;
    localparam logic [3:0]  CH_REGION  = 4'h1;
    localparam logic [3:0]  CH_SUB_RD  = 4'h0;
    localparam logic [3:0]  CH_SUB_THR = 4'h2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RESET,
        ACC_SAMP,
        ACC_MERGED,
        ACC_BLKCNT,
        ACC_CHRD,
        ACC_THR
    } acc_e;

    typedef struct packed {
        acc_e             kind;
        logic [CIDXW-1:0] chan;
    } dec_t;

    function automatic logic am_single(input logic [AMW-1:0] am);
        return am == AM_SINGLE;
    endfunction

    function automatic logic am_block(input logic [AMW-1:0] am);
        return (am == AM_BLOCK_A) || (am == AM_BLOCK_B);
    endfunction

endpackage

// File: rtl/rbd_decode.sv
module rbd_decode
    import rbd_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     slot_id,
    input  logic [AW-1:0]  addr,
    input  logic [AMW-1:0] am,
    input  logic           write,
    input  logic           strobe,
    output dec_t           dec
);

    localparam logic [CIDXW:0] NCH_L = (CIDXW+1)'(NCH);

    logic [15:0] off;
    logic        hit;
    logic        in_chan;

    assign off     = addr[15:0];
    assign hit     = strobe && (addr[AW-1:16] == slot_id);
    assign in_chan = (off[15:12] == CH_REGION) && ({1'b0, off[11:4]} < NCH_L);

    always_comb begin
        dec.kind = ACC_NONE;
        dec.chan = '0;
        if (hit) begin
            if (am_single(am)) begin
                if (write && off == OFF_RESET) begin
                    dec.kind = ACC_RESET;
                end else if (write && off == OFF_SAMP) begin
                    dec.kind = ACC_SAMP;
                end else if (in_chan) begin
                    dec.chan = off[11:4];
                    if (!write && off[3:0] == CH_SUB_RD) begin
                        dec.kind = ACC_CHRD;
                    end else if (write && off[3:0] == CH_SUB_THR) begin
                        dec.kind = ACC_THR;
                    end
                end
            end else if (am_block(am) && !write) begin
                if (off == OFF_MERGED) begin
                    dec.kind = ACC_MERGED;
                end else if (off == OFF_BLKCNT) begin
                    dec.kind = ACC_BLKCNT;
                end
            end
        end
    end

    // R1: a foreign slot byte never decodes
    p_slot_mismatch_r1: assert property (@(posedge clk) disable iff (rst)
        (strobe && addr[AW-1:16] != slot_id) |-> dec.kind == ACC_NONE);

    // R10: block registers never decode with the single-word modifier
    p_block_needs_blk_am_r10: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_MERGED || dec.kind == ACC_BLKCNT) |-> am_block(am));

    // R10: single-word registers never decode with another modifier
    p_single_needs_am_r10: assert property (@(posedge clk) disable iff (rst)
        (dec.kind inside {ACC_RESET, ACC_SAMP, ACC_CHRD, ACC_THR}) |-> am == AM_SINGLE);

endmodule

// File: rtl/rbd_regs.sv
module rbd_regs
    import rbd_pkg::*;
#(
    parameter int            NCH      = 32,
    parameter logic [DW-1:0] DEF_SAMP = 16'd80,
    parameter logic [DW-1:0] DEF_THR  = 16'h0010
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [DW-1:0]     wdata,
    output logic              rst_fire,
    output logic              mod_reset,
    output logic [DW-1:0]     samp_count,
    output logic [NCH*DW-1:0] thr_flat
);

    logic [DW-1:0] thr_q [NCH];

    assign rst_fire = (dec.kind == ACC_RESET) && (wdata == RST_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_reset  <= 1'b0;
            samp_count <= DEF_SAMP;
        end else begin
            mod_reset <= rst_fire;
            if (rst_fire) begin
                samp_count <= DEF_SAMP;
            end else if (dec.kind == ACC_SAMP) begin
                samp_count <= wdata;
            end
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst || rst_fire) begin
                thr_q[k] <= DEF_THR;
            end else if (dec.kind == ACC_THR && dec.chan == CIDXW'(k)) begin
                thr_q[k] <= wdata;
            end
        end
        assign thr_flat[k*DW +: DW] = thr_q[k];
    end

    // R3: the reset pulse coincides with default register contents
    p_reset_defaults_r3: assert property (@(posedge clk) disable iff (rst)
        mod_reset |-> (samp_count == DEF_SAMP && thr_q[0] == DEF_THR && thr_q[NCH-1] == DEF_THR));

    // R4: a reset-offset write without the key leaves the sampling count alone
    p_bad_key_no_effect_r4: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_RESET && wdata != RST_KEY) |=> (!mod_reset && $stable(samp_count)));

    // R5: a sampling-count write lands the following cycle
    p_samp_load_r5: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_SAMP) |=> samp_count == $past(wdata));

endmodule

// File: rtl/rbd_readpath.sv
module rbd_readpath
    import rbd_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  dec_t              dec,
    input  logic              rst_fire,
    input  logic [DW-1:0]     mrg_data,
    input  logic [NCH*DW-1:0] ch_data,
    output logic              mrg_pop,
    output logic [NCH-1:0]    ch_pop,
    output logic [DW-1:0]     rdata,
    output logic              ack
);

    logic [DW-1:0] blk_cnt;
    logic [DW-1:0] ch_word;
    logic [DW-1:0] rd_next;

    assign mrg_pop = (dec.kind == ACC_MERGED);

    for (genvar k = 0; k < NCH; k++) begin : g_pop
        assign ch_pop[k] = (dec.kind == ACC_CHRD) && (dec.chan == CIDXW'(k));
    end

    always_comb begin
        ch_word = '0;
        for (int k = 0; k < NCH; k++) begin
            if (dec.chan == CIDXW'(k)) begin
                ch_word = ch_data[k*DW +: DW];
            end
        end
    end

    always_comb begin
        unique case (dec.kind)
            ACC_MERGED: rd_next = mrg_data;
            ACC_BLKCNT: rd_next = blk_cnt;
            ACC_CHRD:   rd_next = ch_word;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            rdata   <= '0;
            blk_cnt <= '0;
        end else begin
            ack   <= (dec.kind != ACC_NONE);
            rdata <= rd_next;
            if (rst_fire) begin
                blk_cnt <= '0;
            end else if (mrg_pop) begin
                blk_cnt <= blk_cnt + 1'b1;
            end
        end
    end

    // R2: an acknowledge always answers a strobe one cycle earlier
    p_ack_follows_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(strobe));

    // R8: at most one FIFO is popped per cycle
    p_single_pop_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mrg_pop, ch_pop}));

    // R7: each accepted merged read advances the counter by one
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(mrg_pop) && !$past(rst_fire)) |-> blk_cnt == $past(blk_cnt) + 1'b1);

    // R3: a keyed reset clears the counter
    p_count_clear_r3: assert property (@(posedge clk) disable iff (rst)
        rst_fire |=> blk_cnt == '0);

endmodule

// File: rtl/rbus_decoder.sv
module rbus_decoder
    import rbd_pkg::*;
#(
    parameter int            NCH      = 32,
    parameter logic [15:0]   DEF_SAMP = 16'd80,
    parameter logic [15:0]   DEF_THR  = 16'h0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        slot_id,
    input  logic [23:0]       bus_addr,
    input  logic [5:0]        bus_am,
    input  logic              bus_write,
    input  logic              bus_strobe,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_ack,
    input  logic [15:0]       mrg_data,
    output logic              mrg_pop,
    input  logic [NCH*16-1:0] ch_data,
    output logic [NCH-1:0]    ch_pop,
    output logic              mod_reset,
    output logic [15:0]       samp_count,
    output logic [NCH*16-1:0] thr_flat
);

    dec_t dec;
    logic rst_fire;

    rbd_decode #(.NCH(NCH)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .slot_id(slot_id),
        .addr   (bus_addr),
        .am     (bus_am),
        .write  (bus_write),
        .strobe (bus_strobe),
        .dec    (dec)
    );

    rbd_regs #(.NCH(NCH), .DEF_SAMP(DEF_SAMP), .DEF_THR(DEF_THR)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .wdata     (bus_wdata),
        .rst_fire  (rst_fire),
        .mod_reset (mod_reset),
        .samp_count(samp_count),
        .thr_flat  (thr_flat)
    );

    rbd_readpath #(.NCH(NCH)) u_readpath (
        .clk     (clk),
        .rst     (rst),
        .strobe  (bus_strobe),
        .dec     (dec),
        .rst_fire(rst_fire),
        .mrg_data(mrg_data),
        .ch_data (ch_data),
        .mrg_pop (mrg_pop),
        .ch_pop  (ch_pop),
        .rdata   (bus_rdata),
        .ack     (bus_ack)
    );

    // R12: nothing is acknowledged in the cycle after a bus reset
    p_quiet_after_rst_r12: assert property (@(posedge clk)
        $past(rst) |-> (!bus_ack && !mod_reset));

endmodule

// File: tb/test_rbus_decoder.sv
module test_rbus_decoder;

    localparam int   CLK_P = 10;
    localparam int   NCH   = 32;
    localparam logic [7:0] SLOT = 8'h07;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        slot_id = SLOT;
    logic [23:0]       bus_addr = '0;
    logic [5:0]        bus_am = '0;
    logic              bus_write = 1'b0;
    logic              bus_strobe = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              bus_ack;
    logic [15:0]       mrg_data = '0;
    logic              mrg_pop;
    logic [NCH*16-1:0] ch_data;
    logic [NCH-1:0]    ch_pop;
    logic              mod_reset;
    logic [15:0]       samp_count;
    logic [NCH*16-1:0] thr_flat;

    int nvec = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    rbus_decoder i_rbus_decoder (
        .clk(clk), .rst(rst), .slot_id(slot_id),
        .bus_addr(bus_addr), .bus_am(bus_am), .bus_write(bus_write),
        .bus_strobe(bus_strobe), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .mrg_data(mrg_data), .mrg_pop(mrg_pop),
        .ch_data(ch_data), .ch_pop(ch_pop),
        .mod_reset(mod_reset), .samp_count(samp_count), .thr_flat(thr_flat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] thr_of(input int j);
        return thr_flat[j*16 +: 16];
    endfunction

    // one strobe; pops sampled in strobe cycle, response in the next
    task automatic access(input logic wr, input logic [7:0] slot, input logic [15:0] off,
                          input logic [5:0] am, input logic [15:0] wd,
                          output logic ack, output logic [15:0] rd,
                          output logic mp, output logic [NCH-1:0] cp);
        @(negedge clk);
        bus_write  = wr;
        bus_addr   = {slot, off};
        bus_am     = am;
        bus_wdata  = wd;
        bus_strobe = 1'b1;
        #1;
        mp = mrg_pop;
        cp = ch_pop;
        @(negedge clk);
        bus_strobe = 1'b0;
        bus_write  = 1'b0;
        ack = bus_ack;
        rd  = bus_rdata;
    endtask

    logic           a;
    logic [15:0]    r;
    logic           p;
    logic [NCH-1:0] c;

    task automatic t_reset_state();
        chk("R12 ack", 32'(bus_ack), 0);
        chk("R12 mod_reset", 32'(mod_reset), 0);
        chk("R12 samp", 32'(samp_count), 80);
        chk("R12 thr0", 32'(thr_of(0)), 16'h0010);
        chk("R12 thr31", 32'(thr_of(31)), 16'h0010);
        access(1'b0, SLOT, 16'h0101, 6'h3B, 0, a, r, p, c);
        chk("R12 count read ack", 32'(a), 1);
        chk("R12 count zero", 32'(r), 0);
    endtask

    task automatic t_samp();
        access(1'b1, SLOT, 16'h0001, 6'h3D, 16'd600, a, r, p, c);
        chk("R2 ack", 32'(a), 1);
        chk("R5 samp", 32'(samp_count), 600);
        @(negedge clk);
        chk("R2 ack one cycle", 32'(bus_ack), 0);
    endtask

    task automatic t_thr();
        access(1'b1, SLOT, 16'h1052, 6'h3D, 16'h0123, a, r, p, c);
        chk("R9 ack", 32'(a), 1);
        chk("R9 thr5", 32'(thr_of(5)), 16'h0123);
        chk("R9 thr4 untouched", 32'(thr_of(4)), 16'h0010);
        chk("R9 thr6 untouched", 32'(thr_of(6)), 16'h0010);
        access(1'b1, SLOT, 16'h11F2, 6'h3D, 16'h0777, a, r, p, c);
        chk("R9 thr31", 32'(thr_of(31)), 16'h0777);
    endtask

    task automatic t_merged();
        mrg_data = 16'hA5A5;
        access(1'b0, SLOT, 16'h0100, 6'h3B, 0, a, r, p, c);
        chk("R6 pop 3B", 32'(p), 1);
        chk("R6 no chan pop", 32'(c), 0);
        chk("R6 data 3B", 32'(r), 16'hA5A5);
        chk("R2 read ack", 32'(a), 1);
        mrg_data = 16'h5A5A;
        access(1'b0, SLOT, 16'h0100, 6'h3F, 0, a, r, p, c);
        chk("R6 pop 3F", 32'(p), 1);
        chk("R6 data 3F", 32'(r), 16'h5A5A);
        access(1'b0, SLOT, 16'h0101, 6'h3F, 0, a, r, p, c);
        chk("R7 count", 32'(r), 2);
        chk("R7 count read no pop", 32'(p), 0);
    endtask

    task automatic t_chan();
        access(1'b0, SLOT, 16'h1070, 6'h3D, 0, a, r, p, c);
        chk("R8 pop7", 32'(c), 32'h0000_0080);
        chk("R8 data7", 32'(r), 16'hC007);
        chk("R8 no merged pop", 32'(p), 0);
        access(1'b0, SLOT, 16'h1000, 6'h3D, 0, a, r, p, c);
        chk("R8 pop0", 32'(c), 32'h0000_0001);
        chk("R8 data0", 32'(r), 16'hC000);
        access(1'b0, SLOT, 16'h11F0, 6'h3D, 0, a, r, p, c);
        chk("R8 pop31", 32'(c), 32'h8000_0000);
        chk("R8 data31", 32'(r), 16'hC01F);
        access(1'b0, SLOT, 16'h1200, 6'h3D, 0, a, r, p, c);
        chk("R11 chan32 ack", 32'(a), 0);
        chk("R11 chan32 pop", 32'(c), 0);
    endtask

    task automatic t_bad_am();
        access(1'b0, SLOT, 16'h0100, 6'h3D, 0, a, r, p, c);
        chk("R10 merged 3D ack", 32'(a), 0);
        chk("R10 merged 3D pop", 32'(p), 0);
        access(1'b1, SLOT, 16'h0001, 6'h3B, 16'd11, a, r, p, c);
        chk("R10 samp 3B ack", 32'(a), 0);
        chk("R10 samp unchanged", 32'(samp_count), 600);
        access(1'b0, SLOT, 16'h1070, 6'h09, 0, a, r, p, c);
        chk("R10 chan 09 ack", 32'(a), 0);
        chk("R10 chan 09 pop", 32'(c), 0);
        access(1'b1, SLOT, 16'h1052, 6'h3F, 16'h0999, a, r, p, c);
        chk("R10 thr 3F unchanged", 32'(thr_of(5)), 16'h0123);
    endtask

    task automatic t_slot();
        access(1'b1, 8'h08, 16'h0001, 6'h3D, 16'd5, a, r, p, c);
        chk("R1 other slot ack", 32'(a), 0);
        chk("R1 samp unchanged", 32'(samp_count), 600);
        access(1'b0, 8'h06, 16'h0100, 6'h3B, 0, a, r, p, c);
        chk("R1 other slot pop", 32'(p), 0);
    endtask

    task automatic t_unmapped();
        access(1'b0, SLOT, 16'h0002, 6'h3D, 0, a, r, p, c);
        chk("R11 unmapped ack", 32'(a), 0);
        access(1'b0, SLOT, 16'h0001, 6'h3D, 0, a, r, p, c);
        chk("R11 read write-only ack", 32'(a), 0);
        access(1'b1, SLOT, 16'h0100, 6'h3B, 16'h1, a, r, p, c);
        chk("R11 write read-only ack", 32'(a), 0);
        chk("R11 write read-only pop", 32'(p), 0);
        access(1'b1, SLOT, 16'h1070, 6'h3D, 16'h1, a, r, p, c);
        chk("R11 write chan fifo ack", 32'(a), 0);
    endtask

    task automatic t_reset_key();
        access(1'b1, SLOT, 16'h0000, 6'h3D, 16'h0101, a, r, p, c);
        chk("R4 ack", 32'(a), 1);
        chk("R4 no pulse", 32'(mod_reset), 0);
        chk("R4 samp kept", 32'(samp_count), 600);
        chk("R4 thr kept", 32'(thr_of(5)), 16'h0123);
        access(1'b1, SLOT, 16'h0000, 6'h3D, 16'h0100, a, r, p, c);
        chk("R3 ack", 32'(a), 1);
        chk("R3 pulse", 32'(mod_reset), 1);
        chk("R3 samp default", 32'(samp_count), 80);
        chk("R3 thr5 default", 32'(thr_of(5)), 16'h0010);
        chk("R3 thr31 default", 32'(thr_of(31)), 16'h0010);
        @(negedge clk);
        chk("R3 pulse one cycle", 32'(mod_reset), 0);
        access(1'b0, SLOT, 16'h0101, 6'h3B, 0, a, r, p, c);
        chk("R3 count cleared", 32'(r), 0);
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) ch_data[k*16 +: 16] = 16'hC000 | 16'(k);
    end

    initial begin : watchdog
        #(CLK_P * 20000);
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_samp();
        t_thr();
        t_merged();
        t_chan();
        t_bad_am();
        t_slot();
        t_unmapped();
        t_reset_key();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule